// File: doc/BRIEF.md
# Cross-Channel Sample Averaging Combiner

This block receives one corrected and clipped conversion sample from each of eight parallel channels. All eight samples arrive together under a single valid strobe. A 2-bit mode input selects one of four behaviours. The block can forward every channel to its own output lane. It can also average neighbouring channels in groups of two, four or eight, which trades lane count for lower uncorrelated noise. The averaged values go out on a fixed set of low-numbered lanes, and the remaining lanes drive zero.

Each output lane also carries an overrange flag. On an averaging lane, this flag is set when any channel in that lane's group reported overrange. The group sum is formed at full width and divided by a rounding arithmetic shift. The quotient is then limited to the sample range. Results and a matching valid strobe are registered one clock after the input strobe. They hold their value until the next input strobe.

Top module: `chavg_combiner`

## Requirements
- R1: While `rst` is high at a clock edge, `out_vld`, every lane of `out_data` and every bit of `out_ovr` become 0 after that edge.
- R2: `out_vld` is high for exactly one cycle, in the cycle that follows each cycle in which `in_vld` is high, and it is low at all other times.
- R3: With mode 2'b00 (averaging off), lane n carries channel n (bits n*24 +: 24) and its overrange flag, for n = 0..7.
- R4: With mode 2'b01, lane k (k = 0..3) carries the average of channels 2k and 2k+1.
- R5: With mode 2'b10, lane 0 carries the average of channels 0..3 and lane 1 carries the average of channels 4..7.
- R6: With mode 2'b11, lane 0 carries the average of channels 0..7.
- R7: In any averaging mode, the lanes beyond the averaged ones output 0 with the overrange flag low, so no single-channel value appears on any lane.
- R8: An average is the signed two's-complement group sum plus half of the divisor, shifted right arithmetically by log2 of the group size (round half up). For example, the pair (-1, 0) gives 0 and the pair (-3, 0) gives -1.
- R9: Inputs at full scale enter the average unchanged and the result stays inside the 24-bit range. For example, an all-0x7FFFFF group gives 0x7FFFFF and an all-0x800000 group gives 0x800000.
- R10: The overrange flag of an averaging lane is the OR of the input overrange flags of all channels in that lane's group.
- R11: Changes on `mode`, `in_data` or `in_ovr` while `in_vld` is low do not change `out_data` or `out_ovr`; a new mode acts only at the next `in_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Strobe marking a set of eight samples |
| mode | input | 2 | 00 off, 01 pairs, 10 quads, 11 all eight |
| in_data | input | 192 | Eight 24-bit signed samples, channel n at bits n*24 +: 24 |
| in_ovr | input | 8 | Per-channel overrange flag, bit n for channel n |
| out_vld | output | 1 | Registered result strobe |
| out_data | output | 192 | Eight 24-bit lanes, lane n at bits n*24 +: 24 |
| out_ovr | output | 8 | Per-lane overrange flag |

## Verification
The assertions check on every cycle that the output strobe follows the input strobe, and that outputs hold between strobes. They also check that pass-through lanes copy their inputs, that lanes beyond the active count stay zero with their flag low, and that the flag of the eight-channel lane is the OR of all input flags. Only the bench scenarios can confirm the arithmetic. These cover the half-up rounding at negative and positive odd sums, full-scale groups at both ends of the range, the pair and quad lane mappings under random data, and a mode change made while the strobe is low.

// File: rtl/chavg_pkg.sv
package chavg_pkg;
    localparam int CH_N = 8;

    typedef enum logic [1:0] {
        AVG_OFF  = 2'b00,
        AVG_PAIR = 2'b01,
        AVG_QUAD = 2'b10,
        AVG_OCT  = 2'b11
    } avg_mode_e;

    function automatic int lanes_active(input logic [1:0] m);
        case (m)
            2'b01:   return CH_N / 2;
            2'b10:   return CH_N / 4;
            2'b11:   return CH_N / 8;
            default: return CH_N;
        endcase
    endfunction
endpackage

// File: rtl/chavg_group_sum.sv
module chavg_group_sum #(
    parameter int DATA_W = 24,
    parameter int GRP_N  = 2,
    parameter int SUM_W  = DATA_W + 3
) (
    input  logic [GRP_N*DATA_W-1:0] grp_data,
    input  logic [GRP_N-1:0]        grp_ovr,
    output logic signed [SUM_W-1:0] grp_sum,
    output logic                    grp_any_ovr
);
    always_comb begin
        logic signed [SUM_W-1:0] acc_d;
        acc_d = '0;
        for (int i = 0; i < GRP_N; i++) begin
            acc_d = acc_d + $signed({{(SUM_W-DATA_W){grp_data[i*DATA_W+DATA_W-1]}},
                                     grp_data[i*DATA_W +: DATA_W]});
        end
        grp_sum     = acc_d;
        grp_any_ovr = |grp_ovr;
    end
endmodule

// File: rtl/chavg_scale.sv
module chavg_scale #(
    parameter int DATA_W = 24,
    parameter int SUM_W  = DATA_W + 3,
    parameter int SHIFT  = 1
) (
    input  logic signed [SUM_W-1:0] sum_in,
    output logic [DATA_W-1:0]       avg_out
);
    localparam int RND_W = SUM_W + 1;
    localparam longint MAX_L = (longint'(1) <<< (DATA_W - 1)) - 1;
    localparam longint MIN_L = -(longint'(1) <<< (DATA_W - 1));
    localparam logic signed [RND_W-1:0] HALF_C = RND_W'(longint'(1) <<< (SHIFT - 1));
    localparam logic signed [RND_W-1:0] MAX_C  = RND_W'(MAX_L);
    localparam logic signed [RND_W-1:0] MIN_C  = RND_W'(MIN_L);

    logic signed [RND_W-1:0] rnd_d;
    logic signed [RND_W-1:0] shf_d;

    always_comb begin
        rnd_d = $signed({sum_in[SUM_W-1], sum_in}) + HALF_C;
        shf_d = rnd_d >>> SHIFT;
        if (shf_d > MAX_C) begin
            avg_out = MAX_C[DATA_W-1:0];
        end else if (shf_d < MIN_C) begin
            avg_out = MIN_C[DATA_W-1:0];
        end else begin
            avg_out = shf_d[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/chavg_combiner.sv
module chavg_combiner
    import chavg_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_vld,
    input  logic [1:0]             mode,
    input  logic [CH_N*DATA_W-1:0] in_data,
    input  logic [CH_N-1:0]        in_ovr,
    output logic                   out_vld,
    output logic [CH_N*DATA_W-1:0] out_data,
    output logic [CH_N-1:0]        out_ovr
);
    localparam int SUM_W  = DATA_W + 3;
    localparam int PAIR_N = CH_N / 2;
    localparam int QUAD_N = CH_N / 4;

    typedef struct packed {
        logic                   vld;
        logic [1:0]             mode;
        logic [CH_N*DATA_W-1:0] data;
        logic [CH_N-1:0]        ovr;
    } comb_state_t;

    comb_state_t st_d, st_q;

    logic [DATA_W-1:0] pair_avg [PAIR_N];
    logic [PAIR_N-1:0] pair_ovr;
    logic [DATA_W-1:0] quad_avg [QUAD_N];
    logic [QUAD_N-1:0] quad_ovr;
    logic [DATA_W-1:0] oct_avg;
    logic              oct_ovr;

    for (genvar g = 0; g < PAIR_N; g++) begin : g_pair
        logic signed [SUM_W-1:0] s_sum;
        chavg_group_sum #(.DATA_W(DATA_W), .GRP_N(2), .SUM_W(SUM_W)) u_sum (
            .grp_data   (in_data[g*2*DATA_W +: 2*DATA_W]),
            .grp_ovr    (in_ovr[g*2 +: 2]),
            .grp_sum    (s_sum),
            .grp_any_ovr(pair_ovr[g])
        );
        chavg_scale #(.DATA_W(DATA_W), .SUM_W(SUM_W), .SHIFT(1)) u_scl (
            .sum_in (s_sum),
            .avg_out(pair_avg[g])
        );
    end

    for (genvar g = 0; g < QUAD_N; g++) begin : g_quad
        logic signed [SUM_W-1:0] s_sum;
        chavg_group_sum #(.DATA_W(DATA_W), .GRP_N(4), .SUM_W(SUM_W)) u_sum (
            .grp_data   (in_data[g*4*DATA_W +: 4*DATA_W]),
            .grp_ovr    (in_ovr[g*4 +: 4]),
            .grp_sum    (s_sum),
            .grp_any_ovr(quad_ovr[g])
        );
        chavg_scale #(.DATA_W(DATA_W), .SUM_W(SUM_W), .SHIFT(2)) u_scl (
            .sum_in (s_sum),
            .avg_out(quad_avg[g])
        );
    end

    logic signed [SUM_W-1:0] oct_sum;
    chavg_group_sum #(.DATA_W(DATA_W), .GRP_N(8), .SUM_W(SUM_W)) u_oct_sum (
        .grp_data   (in_data),
        .grp_ovr    (in_ovr),
        .grp_sum    (oct_sum),
        .grp_any_ovr(oct_ovr)
    );
    chavg_scale #(.DATA_W(DATA_W), .SUM_W(SUM_W), .SHIFT(3)) u_oct_scl (
        .sum_in (oct_sum),
        .avg_out(oct_avg)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (in_vld) begin
            st_d.vld  = 1'b1;
            st_d.mode = mode;
            st_d.data = '0;
            st_d.ovr  = '0;
            case (avg_mode_e'(mode))
                AVG_PAIR: begin
                    for (int k = 0; k < PAIR_N; k++) begin
                        st_d.data[k*DATA_W +: DATA_W] = pair_avg[k];
                        st_d.ovr[k] = pair_ovr[k];
                    end
                end
                AVG_QUAD: begin
                    for (int k = 0; k < QUAD_N; k++) begin
                        st_d.data[k*DATA_W +: DATA_W] = quad_avg[k];
                        st_d.ovr[k] = quad_ovr[k];
                    end
                end
                AVG_OCT: begin
                    st_d.data[DATA_W-1:0] = oct_avg;
                    st_d.ovr[0] = oct_ovr;
                end
                default: begin
                    st_d.data = in_data;
                    st_d.ovr  = in_ovr;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld;
    assign out_data = st_q.data;
    assign out_ovr  = st_q.ovr;

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_data) && $stable(out_ovr)));
    // R3
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && mode == AVG_OFF) |=> (out_data == $past(in_data) && out_ovr == $past(in_ovr)));
    // R10
    oct_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && mode == AVG_OCT) |=> (out_ovr[0] == $past(|in_ovr)));

    for (genvar l = 0; l < CH_N; l++) begin : g_lane_chk
        // R7
        idle_lane_chk: assert property (@(posedge clk) disable iff (rst)
            (l >= lanes_active(st_q.mode)) |->
                (out_data[l*DATA_W +: DATA_W] == '0 && !out_ovr[l]));
    end
endmodule

// File: tb/chavg_combiner_test.sv
module chavg_combiner_test;
    localparam int NC = 8;
    localparam int DW = 24;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_vld = 1'b0;
    logic [1:0]      mode = 2'b00;
    logic [NC*DW-1:0] in_data = '0;
    logic [NC-1:0]   in_ovr = '0;
    logic            out_vld;
    logic [NC*DW-1:0] out_data;
    logic [NC-1:0]   out_ovr;

    int n_chk = 0;
    int n_err = 0;
    logic signed [DW-1:0] ch [NC];

    always #2 clk = ~clk;

    chavg_combiner uut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .mode(mode),
        .in_data(in_data), .in_ovr(in_ovr),
        .out_vld(out_vld), .out_data(out_data), .out_ovr(out_ovr)
    );

    function automatic logic [NC*DW-1:0] pack_ch();
        logic [NC*DW-1:0] v;
        for (int i = 0; i < NC; i++) v[i*DW +: DW] = ch[i];
        return v;
    endfunction

    function automatic logic [DW-1:0] ref_avg(input int first, input int k);
        longint s = 0;
        longint r;
        for (int i = 0; i < (1 << k); i++) s += longint'(ch[first+i]);
        r = (s + (longint'(1) << (k-1))) >>> k;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
        return r[DW-1:0];
    endfunction

    function automatic void ref_out(input logic [1:0] m, input logic [NC-1:0] fl,
                                    output logic [NC*DW-1:0] ed, output logic [NC-1:0] ef);
        int k;
        int g;
        ed = '0;
        ef = '0;
        if (m == 2'b00) begin
            ed = pack_ch();
            ef = fl;
        end else begin
            k = int'(m);
            g = 1 << k;
            for (int l = 0; l < NC / g; l++) begin
                ed[l*DW +: DW] = ref_avg(l*g, k);
                ef[l] = |((fl >> (l*g)) & NC'((1 << g) - 1));
            end
        end
    endfunction

    task automatic check(input string req, input logic [NC*DW-1:0] act_d,
                         input logic [NC*DW-1:0] exp_d, input logic [NC-1:0] act_f,
                         input logic [NC-1:0] exp_f);
        n_chk++;
        if (act_d !== exp_d || act_f !== exp_f) begin
            n_err++;
            $display("FAIL %s: data=%h ovr=%b expected data=%h ovr=%b",
                     req, act_d, act_f, exp_d, exp_f);
        end
    endtask

    task automatic run_one(input logic [1:0] m, input logic [NC-1:0] fl, input string req);
        logic [NC*DW-1:0] ed;
        logic [NC-1:0] ef;
        @(negedge clk);
        in_data = pack_ch();
        in_ovr  = fl;
        mode    = m;
        in_vld  = 1'b1;
        ref_out(m, fl, ed, ef);
        @(negedge clk);
        in_vld = 1'b0;
        check(req, out_data, ed, out_ovr, ef);
        check("R2 strobe high", {191'b0, out_vld}, {191'b0, 1'b1}, '0, '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        logic [NC*DW-1:0] held_d;
        logic [NC-1:0] held_f;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", out_data, '0, out_ovr, '0);
        check("R1 reset strobe", {191'b0, out_vld}, '0, '0, '0);
        rst = 1'b0;

        // R3 pass-through with flags
        for (int i = 0; i < NC; i++) ch[i] = DW'(i * 1000 - 3500);
        run_one(2'b00, 8'b1010_0110, "R3 pass-through");
        @(negedge clk);
        check("R2 strobe low", {191'b0, out_vld}, '0, '0, '0);

        // R8 rounding half up, negative and positive odd sums
        for (int i = 0; i < NC; i++) ch[i] = '0;
        ch[0] = -1; ch[2] = -3; ch[4] = 1; ch[6] = 3;
        run_one(2'b01, 8'h00, "R8 rounding pairs");
        ch[0] = -2; ch[4] = 2; ch[2] = 0; ch[6] = 0;
        run_one(2'b10, 8'h00, "R8 rounding quads");
        for (int i = 0; i < NC; i++) ch[i] = '0;
        ch[3] = -4;
        run_one(2'b11, 8'h00, "R8 rounding octet -4/8");

        // R9 full scale both ends
        for (int i = 0; i < NC; i++) ch[i] = 24'sh7FFFFF;
        run_one(2'b11, 8'h00, "R9 positive full scale");
        for (int i = 0; i < NC; i++) ch[i] = 24'sh800000;
        run_one(2'b11, 8'h00, "R9 negative full scale");
        run_one(2'b01, 8'h00, "R9 negative full scale pairs");

        // R10 single flag propagates, R7 upper lanes clear their flag
        for (int i = 0; i < NC; i++) ch[i] = DW'(i * 77);
        run_one(2'b11, 8'b1000_0000, "R10 octet flag from ch7");
        run_one(2'b10, 8'b0010_0000, "R10 quad flag from ch5");
        run_one(2'b01, 8'b1111_0000, "R7 upper flags cleared");

        // R11 mode and data changes without strobe are ignored
        run_one(2'b01, 8'b0000_0010, "R4 before hold");
        held_d = out_data;
        held_f = out_ovr;
        mode = 2'b00;
        in_ovr = 8'hFF;
        in_data = {NC{24'h123456}};
        repeat (3) @(negedge clk);
        check("R11 hold without strobe", out_data, held_d, out_ovr, held_f);

        // Random mix across all modes, R4 R5 R6 R7 R10 under random data
        for (int t = 0; t < 300; t++) begin
            logic [1:0] m;
            logic [NC-1:0] fl;
            string tag;
            m = 2'($urandom % 4);
            fl = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
            for (int i = 0; i < NC; i++) begin
                case ($urandom % 8)
                    0: ch[i] = 24'sh7FFFFF;
                    1: ch[i] = 24'sh800000;
                    default: ch[i] = DW'($urandom);
                endcase
            end
            case (m)
                2'b00: tag = "R3 random";
                2'b01: tag = "R4 R7 random";
                2'b10: tag = "R5 R7 random";
                default: tag = "R6 R7 random";
            endcase
            run_one(m, fl, tag);
            if ($urandom % 4 == 0) @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule